// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block sequences a phase-shifted bridge controller through power-up, a gradual start, normal operation, a controlled wind-down and an abrupt shutdown. It watches four things every clock: a digitized supply level, a flag that says the internal reference is healthy, an external shutdown request, and a digitized current-sense sample. From these it keeps a digital soft-start ramp register. That register limits the PWM command the bridge generator may use. The block also drives an enable for that generator and a low-power flag that is raised only while the supply is locked out.

An overcurrent sample does not kill the ramp. It starts a soft-stop in which the ramp falls ten times faster than it rose. Once the ramp is below one tenth of full scale, a fresh soft-start begins on its own. A bad supply, a bad reference or an external shutdown instead clears the ramp at the next edge. Every fault removes the drive enable in the same cycle it is seen.

Top module: `softstart_supervisor`

## Requirements
- R1: While reset is active and directly after it: `low_power`=1, `ramp_level`=0, `drive_en`=0, `pwm_cmd_out`=0.
- R2: The supply code uses 16 codes per volt. Lockout releases on the edge after `supply_code` > 176 (11 V) and re-asserts on the edge after `supply_code` < 144 (9 V). Codes 144..176 hold the present lockout state. `low_power` equals the lockout state and nothing else.
- R3: During lockout, or while `ref_good`=0, `drive_en` is 0 in that same cycle and `ramp_level` is 0 from the next edge.
- R4: `disable_req`=1 removes `drive_en` in the same cycle and clears `ramp_level` at the next edge. It leaves `low_power` at 0.
- R5: Once no fault is present, the ramp starts from 0. It then rises by 4 per clock and saturates at 1023. The edge at which it reaches 1023 enters run, where it stays at 1023.
- R6: `isense` >= 128 (half scale) during soft-start or run drops `drive_en` in that cycle. It starts a soft-stop in which the ramp falls by 40 per clock, with a floor of 0. `isense` = 127 has no effect.
- R7: A soft-stop ends on the first edge at which the ramp is below 102. At that edge soft-start resumes and the ramp is increased by 4. A new overcurrent during the soft-stop is ignored.
- R8: `pwm_cmd_out` equals min(`pwm_cmd_in`, `ramp_level`) while `drive_en`=1 and 0 otherwise. `drive_en`=1 only in soft-start or run with no fault present in the cycle.
- R9: Fault priority is lockout, then reference, then external disable, then overcurrent. A disable together with an overcurrent clears the ramp instead of ramping it down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_code | input | 8 | Supply level, 16 codes per volt |
| ref_good | input | 1 | Internal reference healthy |
| disable_req | input | 1 | External shutdown request |
| isense | input | 8 | Current-sense sample, 256 codes full scale |
| pwm_cmd_in | input | 10 | Requested PWM command |
| ramp_level | output | 10 | Soft-start ramp register |
| pwm_cmd_out | output | 10 | Command after ramp clamp and enable gating |
| drive_en | output | 1 | Enable to the PWM generator |
| low_power | output | 1 | Undervoltage lockout in force |

## Verification
The assertions assume that the inputs are synchronous to `clk` and stable across each edge. They also assume that the ramp step sizes leave a full-scale ramp able to reach the soft-stop exit threshold. The bench therefore changes every input shortly after a rising edge and leaves the step parameters at their defaults. It walks the supply code over both hysteresis thresholds and their neighbours, and steps `isense` across the overcurrent boundary. It also sweeps `pwm_cmd_in` over the whole code range while a per-cycle arithmetic model follows the ramp.

// File: rtl/ss_sup_pkg.sv
package ss_sup_pkg;
    typedef enum logic [2:0] {
        ST_LOCK      = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_RUN       = 3'd2,
        ST_SOFTSTOP  = 3'd3,
        ST_DISABLED  = 3'd4
    } sup_state_e;

    typedef enum logic [1:0] {
        RAMP_HOLD  = 2'd0,
        RAMP_UP    = 2'd1,
        RAMP_DOWN  = 2'd2,
        RAMP_CLEAR = 2'd3
    } ramp_op_e;
endpackage

// File: rtl/sup_uvlo_hyst.sv
module sup_uvlo_hyst #(
    parameter int SUP_W   = 8,
    parameter int ON_LVL  = 176,
    parameter int OFF_LVL = 144
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUP_W-1:0] supply_code,
    output logic             locked
);
    logic locked_d, locked_q;

    always_comb begin
        locked_d = locked_q;
        if (locked_q && (int'(supply_code) > ON_LVL))
            locked_d = 1'b0;
        else if (!locked_q && (int'(supply_code) < OFF_LVL))
            locked_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) locked_q <= 1'b1;
        else        locked_q <= locked_d;
    end

    assign locked = locked_q;

    // R2: inside the hysteresis band the lockout state does not move
    a_r2_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(supply_code) >= OFF_LVL && int'(supply_code) <= ON_LVL) |=> $stable(locked_q));
    // R2: a high supply always ends up released
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(supply_code) > ON_LVL) |=> !locked_q);
endmodule

// File: rtl/sup_ramp_gen.sv
module sup_ramp_gen
    import ss_sup_pkg::*;
#(
    parameter int RAMP_W    = 10,
    parameter int RISE_STEP = 4,
    parameter int FALL_MULT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ramp_op_e          op,
    output logic [RAMP_W-1:0] ramp
);
    localparam int RAMP_MAX  = (1 << RAMP_W) - 1;
    localparam int FALL_STEP = RISE_STEP * FALL_MULT;

    logic [RAMP_W-1:0] ramp_d, ramp_q;
    logic [RAMP_W:0]   sum_w;

    always_comb begin
        sum_w  = {1'b0, ramp_q} + (RAMP_W+1)'(RISE_STEP);
        ramp_d = ramp_q;
        unique case (op)
            RAMP_UP:    ramp_d = (int'(sum_w) > RAMP_MAX) ? RAMP_W'(RAMP_MAX) : sum_w[RAMP_W-1:0];
            RAMP_DOWN:  ramp_d = (int'(ramp_q) > FALL_STEP) ? ramp_q - RAMP_W'(FALL_STEP) : '0;
            RAMP_CLEAR: ramp_d = '0;
            default:    ramp_d = ramp_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ramp_q <= '0;
        else        ramp_q <= ramp_d;
    end

    assign ramp = ramp_q;

    // R6: a down step never increases the ramp
    a_r6_down_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAMP_DOWN) |=> (ramp_q <= $past(ramp_q)));
    // R5: an up step never decreases the ramp
    a_r5_up_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAMP_UP) |=> (ramp_q >= $past(ramp_q)));
endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor
    import ss_sup_pkg::*;
#(
    parameter int SUP_W     = 8,
    parameter int UVLO_ON   = 176,
    parameter int UVLO_OFF  = 144,
    parameter int CS_W      = 8,
    parameter int OC_LEVEL  = 128,
    parameter int RAMP_W    = 10,
    parameter int RISE_STEP = 4,
    parameter int FALL_MULT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUP_W-1:0]  supply_code,
    input  logic              ref_good,
    input  logic              disable_req,
    input  logic [CS_W-1:0]   isense,
    input  logic [RAMP_W-1:0] pwm_cmd_in,
    output logic [RAMP_W-1:0] ramp_level,
    output logic [RAMP_W-1:0] pwm_cmd_out,
    output logic              drive_en,
    output logic              low_power
);
    localparam int RAMP_MAX  = (1 << RAMP_W) - 1;
    localparam int EXIT_LVL  = RAMP_MAX / 10;
    localparam int TOP_LVL   = RAMP_MAX - RISE_STEP;

    typedef struct packed {
        sup_state_e st;
        ramp_op_e   op;
    } nxt_t;

    nxt_t       nx;
    sup_state_e st_q;
    logic       locked;
    logic       oc_hit;
    logic       hard_off;
    logic [RAMP_W-1:0] ramp_q;

    sup_uvlo_hyst #(.SUP_W(SUP_W), .ON_LVL(UVLO_ON), .OFF_LVL(UVLO_OFF)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .locked(locked)
    );

    sup_ramp_gen #(.RAMP_W(RAMP_W), .RISE_STEP(RISE_STEP), .FALL_MULT(FALL_MULT)) u_ramp (
        .clk(clk), .rst_n(rst_n), .op(nx.op), .ramp(ramp_q)
    );

    assign oc_hit   = int'(isense) >= OC_LEVEL;
    assign hard_off = !ref_good || disable_req;

    always_comb begin
        nx.st = st_q;
        nx.op = RAMP_HOLD;
        if (locked) begin
            nx.st = ST_LOCK;
            nx.op = RAMP_CLEAR;
        end else if (hard_off) begin
            nx.st = ST_DISABLED;
            nx.op = RAMP_CLEAR;
        end else if (st_q == ST_SOFTSTOP) begin
            if (int'(ramp_q) < EXIT_LVL) begin
                nx.st = ST_SOFTSTART;
                nx.op = RAMP_UP;
            end else begin
                nx.op = RAMP_DOWN;
            end
        end else if (oc_hit) begin
            nx.st = ST_SOFTSTOP;
            nx.op = RAMP_DOWN;
        end else begin
            unique case (st_q)
                ST_LOCK, ST_DISABLED: nx.st = ST_SOFTSTART;
                ST_SOFTSTART: begin
                    nx.op = RAMP_UP;
                    if (int'(ramp_q) >= TOP_LVL) nx.st = ST_RUN;
                end
                default: nx.op = RAMP_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOCK;
        else        st_q <= nx.st;
    end

    always_comb begin
        drive_en = ((st_q == ST_SOFTSTART) || (st_q == ST_RUN))
                   && !locked && !hard_off && !oc_hit;
        if (!drive_en)               pwm_cmd_out = '0;
        else if (pwm_cmd_in < ramp_q) pwm_cmd_out = pwm_cmd_in;
        else                          pwm_cmd_out = ramp_q;
    end

    assign ramp_level = ramp_q;
    assign low_power  = locked;

    // R3: a bad reference empties the ramp by the next edge
    a_r3_ref_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_good |=> (ramp_q == '0));
    // R3 R4: any hard fault drops the drive in the same cycle
    a_r4_fault_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (locked || !ref_good || disable_req) |-> !drive_en);
    // R8: the command never exceeds the ramp
    a_r8_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_cmd_out <= ramp_q);
    // R7: overcurrent inside a soft-stop does not restart the fall from above
    a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SOFTSTOP && !locked && !hard_off && int'(ramp_q) >= EXIT_LVL)
        |=> (st_q == ST_SOFTSTOP) && (ramp_q < $past(ramp_q) || ramp_q == '0));
    // R5: run is only ever held at full scale
    a_r5_run_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (int'(ramp_q) == RAMP_MAX));
endmodule

// File: tb/softstart_supervisor_test.sv
module softstart_supervisor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] supply_code = 8'd0;
    logic       ref_good = 1'b1;
    logic       disable_req = 1'b0;
    logic [7:0] isense = 8'd0;
    logic [9:0] pwm_cmd_in = 10'd0;
    logic [9:0] ramp_level, pwm_cmd_out;
    logic       drive_en, low_power;

    int n_vec = 0;
    int n_bad = 0;
    int m_lock, m_st, m_ramp, sweep;
    bit done = 0;

    always #10 clk = ~clk;

    softstart_supervisor uut (
        .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .ref_good(ref_good),
        .disable_req(disable_req), .isense(isense), .pwm_cmd_in(pwm_cmd_in),
        .ramp_level(ramp_level), .pwm_cmd_out(pwm_cmd_out),
        .drive_en(drive_en), .low_power(low_power)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model states: 0 lock,1 softstart,2 run,3 softstop,4 disabled
    task automatic compare_model();
        int en, cmd;
        en  = ((m_st == 1 || m_st == 2) && !m_lock && ref_good && !disable_req && isense < 128) ? 1 : 0;
        cmd = en ? ((int'(pwm_cmd_in) < m_ramp) ? int'(pwm_cmd_in) : m_ramp) : 0;
        chk("R2 low_power", int'(low_power), m_lock);
        chk("R5 ramp_level", int'(ramp_level), m_ramp);
        chk("R6 drive_en", int'(drive_en), en);
        chk("R8 pwm_cmd_out", int'(pwm_cmd_out), cmd);
    endtask

    task automatic tick();
        int nl, ns, nr;
        nl = m_lock ? ((supply_code > 176) ? 0 : 1) : ((supply_code < 144) ? 1 : 0);
        ns = m_st; nr = m_ramp;
        if (m_lock) begin ns = 0; nr = 0; end
        else if (!ref_good || disable_req) begin ns = 4; nr = 0; end
        else if (m_st == 3) begin
            if (m_ramp < 102) begin ns = 1; nr = (m_ramp + 4 > 1023) ? 1023 : m_ramp + 4; end
            else nr = (m_ramp > 40) ? m_ramp - 40 : 0;
        end
        else if (isense >= 128) begin ns = 3; nr = (m_ramp > 40) ? m_ramp - 40 : 0; end
        else if (m_st == 0 || m_st == 4) ns = 1;
        else if (m_st == 1) begin
            if (m_ramp >= 1019) ns = 2;
            nr = (m_ramp + 4 > 1023) ? 1023 : m_ramp + 4;
        end
        @(posedge clk);
        #3;
        m_lock = nl; m_st = ns; m_ramp = nr;
        sweep = (sweep + 37) % 1024;
        pwm_cmd_in = 10'(sweep);
        #1;
        compare_model();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int prev;
        m_lock = 1; m_st = 0; m_ramp = 0; sweep = 0;
        #25;
        // R1 reset values
        chk("R1 low_power", int'(low_power), 1);
        chk("R1 ramp_level", int'(ramp_level), 0);
        chk("R1 drive_en", int'(drive_en), 0);
        chk("R1 pwm_cmd_out", int'(pwm_cmd_out), 0);
        @(posedge clk); #3 rst_n = 1'b1;
        supply_code = 8'd160; ticks(5);
        chk("R2 band keeps lockout", int'(low_power), 1);
        supply_code = 8'd176; ticks(3);
        chk("R2 176 not above on level", int'(low_power), 1);
        supply_code = 8'd177; tick();
        chk("R2 release", int'(low_power), 0);
        tick();
        // R5 ramp counted from 0
        ticks(10);
        chk("R5 ramp after 10 rises", int'(ramp_level), 40);
        ticks(260);
        chk("R5 full scale", int'(ramp_level), 1023);
        supply_code = 8'd144; ticks(3);
        chk("R2 144 not below off level", int'(low_power), 0);
        supply_code = 8'd143; tick();
        chk("R2 relock", int'(low_power), 1);
        tick();
        chk("R3 lockout clears ramp", int'(ramp_level), 0);
        supply_code = 8'd200; ticks(60);
        ref_good = 1'b0; #1;
        chk("R3 ref fault drive same cycle", int'(drive_en), 0);
        compare_model(); tick();
        chk("R3 ref fault clears ramp", int'(ramp_level), 0);
        chk("R3 no low power", int'(low_power), 0);
        ref_good = 1'b1; ticks(300);
        // R6 overcurrent boundary
        isense = 8'd127; ticks(4);
        chk("R6 127 ignored", int'(ramp_level), 1023);
        isense = 8'd128; #1;
        chk("R6 drive off same cycle", int'(drive_en), 0);
        compare_model(); tick();
        chk("R6 fall step", int'(ramp_level), 983);
        isense = 8'd0; ticks(5);
        chk("R6 fall continues", int'(ramp_level), 783);
        isense = 8'd255; ticks(3);
        chk("R7 retrigger ignored", int'(ramp_level), 663);
        isense = 8'd0;
        prev = 663;
        while (prev >= 102) begin tick(); prev = int'(ramp_level); end
        tick();
        chk("R7 soft-start resumes", int'(ramp_level), prev + 4);
        ticks(300);
        // R9 disable with overcurrent clears instead of ramping down
        disable_req = 1'b1; isense = 8'd200; tick();
        chk("R9 disable over overcurrent", int'(ramp_level), 0);
        chk("R4 low_power stays clear", int'(low_power), 0);
        supply_code = 8'd100; ticks(2);
        chk("R9 lockout outranks disable", int'(low_power), 1);
        disable_req = 1'b0; isense = 8'd0; supply_code = 8'd250; ticks(300);
        chk("R8 run again", int'(ramp_level), 1023);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule